// File: doc/BRIEF.md
# Combined Jacobian Point Doubling and Addition Unit

This block takes two points of a binary elliptic curve y² + xy = x³ + ax² + b over GF(2^m), both in Jacobian projective form, and returns two results at once: the doubled first point and the sum of the two points. Both results come from a single combinational dataflow in which the addition branch reuses terms already formed by the doubling branch, such as the square of the first Z coordinate. The results are captured in one register stage. The field width, the reduction polynomial and the curve coefficients a and b are parameters, so the same block serves Koblitz-type curves (a, b in {0, 1}) and general binary curves.

A scalar-multiplication sequencer feeds the running accumulator as the first point and the base point as the second. On every step it gets both candidate results, whatever the current key bit is. The block also resolves the special cases that the plain projective formulas do not cover: either input at infinity, two equal points, and two points that are negatives of each other.

Top module: `bin_jac_dbl_add`

## Requirements
- R1: Field elements are FW-bit vectors in polynomial basis, bit i holding the coefficient of x^i, reduced by f(x) = x^FW + FPOLY (defaults: FW = 7, FPOLY = x + 1, a = 1, b = 1); field addition is bitwise XOR. For a finite first point (Z1 ≠ 0) whose affine x is nonzero, the doubled output converted to affine (x = X/Z², y = Y/Z³) equals 2·P1 under the curve group law.
- R2: For two finite points with different affine x, the sum output converted to affine equals P1 + P2.
- R3: For two finite points with the same affine x and different affine y (P2 = −P1), the sum output has Z = 0.
- R4: For two finite inputs that are the same affine point, even with different Z, the sum output equals the doubled output, which converts to 2·P1.
- R5: For a finite first point with affine x = 0, the doubled output has Z = 0.
- R6: When Z1 = 0, the doubled output is exactly (1, 1, 0) and the sum output is exactly (X2, Y2, Z2).
- R7: When Z1 ≠ 0 and Z2 = 0, the sum output is exactly (X1, Y1, Z1).
- R8: out_valid is high in the cycle after the one in which in_valid was sampled high, and both results for that input are on the outputs in that cycle.
- R9: While in_valid is low, out_valid falls and the result outputs keep their last values, whatever the point inputs do.
- R10: While rst_n is low, out_valid and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input points are valid this cycle |
| p1_x | input | FW | First (accumulator) point X |
| p1_y | input | FW | First point Y |
| p1_z | input | FW | First point Z |
| p2_x | input | FW | Second (base) point X |
| p2_y | input | FW | Second point Y |
| p2_z | input | FW | Second point Z |
| out_valid | output | 1 | Results below are fresh |
| dbl_x | output | FW | Doubled point X |
| dbl_y | output | FW | Doubled point Y |
| dbl_z | output | FW | Doubled point Z |
| sum_x | output | FW | Sum point X |
| sum_y | output | FW | Sum point Y |
| sum_z | output | FW | Sum point Z |

## Verification
The case hardest to reach from the ports is the pair of the same affine point given with two different Z values. The formulas then collapse to zero, and the block must detect this and substitute the doubled point. The projective coordinates look unrelated, so random pairs almost never produce it. The bench first lists every point on the small default curve. It then feeds the same table entry twice with independent random Z values, and also feeds an entry with its negation (x, x + y) and the point with x = 0. Every result is compared in affine form against a group-law model built from independent field functions.

// File: rtl/bjda_pkg.sv
// Package: shared selector type and decision function for the
// combined doubling/addition unit. Assumes nothing about field width.
package bjda_pkg;

    // Source of the registered sum result.
    typedef enum logic [1:0] {
        SUM_FORMULA  = 2'd0,
        SUM_TAKE_P2  = 2'd1,
        SUM_TAKE_P1  = 2'd2,
        SUM_TAKE_DBL = 2'd3
    } sum_src_e;

    // Pick the sum source from the special-case flags, first input at infinity first.
    function automatic sum_src_e pick_sum_src(input logic z1_zero,
                                              input logic z2_zero,
                                              input logic w_zero,
                                              input logic r_zero);
        if (z1_zero)
            return SUM_TAKE_P2;
        else if (z2_zero)
            return SUM_TAKE_P1;
        else if (w_zero && r_zero)
            return SUM_TAKE_DBL;
        else
            return SUM_FORMULA;
    endfunction

endpackage

// File: rtl/bjda_gf_mul.sv
// Module: polynomial-basis multiplier in GF(2^FW), most significant
// bit of b first, reducing after each shift.
// Assumes: FPOLY holds the terms of f(x) below x^FW; inputs already reduced.
module bjda_gf_mul #(
    parameter int              FW    = 7,
    parameter logic [FW-1:0]   FPOLY = 'h03
) (
    input  logic [FW-1:0] a,
    input  logic [FW-1:0] b,
    output logic [FW-1:0] p
);
    // Shift-reduce-accumulate over the bits of b.
    always_comb begin
        logic [FW-1:0] acc;
        acc = '0;
        for (int i = FW - 1; i >= 0; i--) begin
            acc = {acc[FW-2:0], 1'b0} ^ (acc[FW-1] ? FPOLY : '0);
            if (b[i])
                acc = acc ^ a;
        end
        p = acc;
    end
endmodule

// File: rtl/bjda_gf_sqr.sv
// Module: squarer in GF(2^FW): spreads the bits into even positions
// and folds the upper half back using f(x).
// Assumes: FPOLY holds the terms of f(x) below x^FW; input reduced.
module bjda_gf_sqr #(
    parameter int              FW    = 7,
    parameter logic [FW-1:0]   FPOLY = 'h03
) (
    input  logic [FW-1:0] a,
    output logic [FW-1:0] s
);
    localparam int WIDE = 2 * FW - 1;

    // Spread then reduce from the top bit down.
    always_comb begin
        logic [WIDE-1:0] t;
        t = '0;
        for (int i = 0; i < FW; i++)
            t[2*i] = a[i];
        for (int j = WIDE - 1; j >= FW; j--) begin
            if (t[j]) begin
                t[j] = 1'b0;
                t[j-FW +: FW] = t[j-FW +: FW] ^ FPOLY;
            end
        end
        s = t[FW-1:0];
    end
endmodule

// File: rtl/bjda_dbl_path.sv
// Module: doubling branch. Z3 = X1*Z1^2, X3 = X1^4 + b*Z1^8,
// Y3 = X1^4*Z3 + (X1^2 + Y1*Z1 + Z3)*X3. Also exports Z1^2 for reuse.
// Assumes: special cases are resolved by the parent.
module bjda_dbl_path #(
    parameter int              FW    = 7,
    parameter logic [FW-1:0]   FPOLY = 'h03,
    parameter logic [FW-1:0]   CB    = 'h01
) (
    input  logic [FW-1:0] x1,
    input  logic [FW-1:0] y1,
    input  logic [FW-1:0] z1,
    output logic [FW-1:0] z1_sq,
    output logic [FW-1:0] dx,
    output logic [FW-1:0] dy,
    output logic [FW-1:0] dz
);
    logic [FW-1:0] x1_sq, x1_4, z1_4, z1_8, bz8, y1z1, mix, t_a, t_b;

    bjda_gf_sqr #(.FW(FW), .FPOLY(FPOLY)) u_sq_z1 (.a(z1),    .s(z1_sq));
    bjda_gf_sqr #(.FW(FW), .FPOLY(FPOLY)) u_sq_x1 (.a(x1),    .s(x1_sq));
    bjda_gf_sqr #(.FW(FW), .FPOLY(FPOLY)) u_sq_x2 (.a(x1_sq), .s(x1_4));
    bjda_gf_sqr #(.FW(FW), .FPOLY(FPOLY)) u_sq_z2 (.a(z1_sq), .s(z1_4));
    bjda_gf_sqr #(.FW(FW), .FPOLY(FPOLY)) u_sq_z4 (.a(z1_4),  .s(z1_8));

    bjda_gf_mul #(.FW(FW), .FPOLY(FPOLY)) u_m_z3  (.a(x1), .b(z1_sq), .p(dz));
    bjda_gf_mul #(.FW(FW), .FPOLY(FPOLY)) u_m_yz  (.a(y1), .b(z1),    .p(y1z1));

    // The coefficient b picks a wire, or a multiplier when it is general.
    generate
        if (CB == FW'(1)) begin : g_b_one
            assign bz8 = z1_8;
        end else begin : g_b_gen
            bjda_gf_mul #(.FW(FW), .FPOLY(FPOLY)) u_m_b (.a(CB), .b(z1_8), .p(bz8));
        end
    endgenerate

    assign dx  = x1_4 ^ bz8;
    assign mix = x1_sq ^ y1z1 ^ dz;

    bjda_gf_mul #(.FW(FW), .FPOLY(FPOLY)) u_m_ta (.a(x1_4), .b(dz), .p(t_a));
    bjda_gf_mul #(.FW(FW), .FPOLY(FPOLY)) u_m_tb (.a(mix),  .b(dx), .p(t_b));

    assign dy = t_a ^ t_b;
endmodule

// File: rtl/bjda_add_path.sv
// Module: addition branch. W = X1*Z2^2 + X2*Z1^2, R = Y1*Z2^3 + Y2*Z1^3,
// Z3 = Z1*Z2*W, X3 = a*Z3^2 + R*(R+Z3) + W^3,
// Y3 = (R+Z3)*X3 + Z1^2*W^2*(R*X2 + Y2*Z1*W).
// Assumes: Z1^2 comes from the doubling branch; parent handles W = R = 0.
module bjda_add_path #(
    parameter int              FW    = 7,
    parameter logic [FW-1:0]   FPOLY = 'h03,
    parameter logic [FW-1:0]   CA    = 'h01
) (
    input  logic [FW-1:0] x1,
    input  logic [FW-1:0] y1,
    input  logic [FW-1:0] z1,
    input  logic [FW-1:0] z1_sq,
    input  logic [FW-1:0] x2,
    input  logic [FW-1:0] y2,
    input  logic [FW-1:0] z2,
    output logic [FW-1:0] ax,
    output logic [FW-1:0] ay,
    output logic [FW-1:0] az,
    output logic          w_zero,
    output logic          r_zero
);
    logic [FW-1:0] z2_sq, z2_cu, z1_cu, u1, u2, s1, s2, w, r;
    logic [FW-1:0] z12, z3_sq, az3, t, rt, w_sq, w_cu;
    logic [FW-1:0] y2z1, y2z1w, rx2, v, z1w_sq, zwv, tx3;

    bjda_gf_sqr #(.FW(FW), .FPOLY(FPOLY)) u_sq_z2 (.a(z2), .s(z2_sq));
    bjda_gf_mul #(.FW(FW), .FPOLY(FPOLY)) u_m_z2c (.a(z2_sq), .b(z2), .p(z2_cu));
    bjda_gf_mul #(.FW(FW), .FPOLY(FPOLY)) u_m_z1c (.a(z1_sq), .b(z1), .p(z1_cu));
    bjda_gf_mul #(.FW(FW), .FPOLY(FPOLY)) u_m_u1  (.a(x1), .b(z2_sq), .p(u1));
    bjda_gf_mul #(.FW(FW), .FPOLY(FPOLY)) u_m_u2  (.a(x2), .b(z1_sq), .p(u2));
    bjda_gf_mul #(.FW(FW), .FPOLY(FPOLY)) u_m_s1  (.a(y1), .b(z2_cu), .p(s1));
    bjda_gf_mul #(.FW(FW), .FPOLY(FPOLY)) u_m_s2  (.a(y2), .b(z1_cu), .p(s2));

    assign w = u1 ^ u2;
    assign r = s1 ^ s2;
    assign w_zero = (w == '0);
    assign r_zero = (r == '0);

    bjda_gf_mul #(.FW(FW), .FPOLY(FPOLY)) u_m_z12 (.a(z1), .b(z2), .p(z12));
    bjda_gf_mul #(.FW(FW), .FPOLY(FPOLY)) u_m_z3  (.a(z12), .b(w), .p(az));
    bjda_gf_sqr #(.FW(FW), .FPOLY(FPOLY)) u_sq_z3 (.a(az), .s(z3_sq));

    // The coefficient a picks zero, a wire, or a multiplier.
    generate
        if (CA == '0) begin : g_a_zero
            assign az3 = '0;
        end else if (CA == FW'(1)) begin : g_a_one
            assign az3 = z3_sq;
        end else begin : g_a_gen
            bjda_gf_mul #(.FW(FW), .FPOLY(FPOLY)) u_m_a (.a(CA), .b(z3_sq), .p(az3));
        end
    endgenerate

    assign t = r ^ az;
    bjda_gf_mul #(.FW(FW), .FPOLY(FPOLY)) u_m_rt  (.a(r), .b(t), .p(rt));
    bjda_gf_sqr #(.FW(FW), .FPOLY(FPOLY)) u_sq_w  (.a(w), .s(w_sq));
    bjda_gf_mul #(.FW(FW), .FPOLY(FPOLY)) u_m_wc  (.a(w_sq), .b(w), .p(w_cu));

    assign ax = az3 ^ rt ^ w_cu;

    bjda_gf_mul #(.FW(FW), .FPOLY(FPOLY)) u_m_yz  (.a(y2), .b(z1), .p(y2z1));
    bjda_gf_mul #(.FW(FW), .FPOLY(FPOLY)) u_m_yzw (.a(y2z1), .b(w), .p(y2z1w));
    bjda_gf_mul #(.FW(FW), .FPOLY(FPOLY)) u_m_rx2 (.a(r), .b(x2), .p(rx2));
    assign v = rx2 ^ y2z1w;
    bjda_gf_mul #(.FW(FW), .FPOLY(FPOLY)) u_m_zw  (.a(z1_sq), .b(w_sq), .p(z1w_sq));
    bjda_gf_mul #(.FW(FW), .FPOLY(FPOLY)) u_m_zwv (.a(z1w_sq), .b(v), .p(zwv));
    bjda_gf_mul #(.FW(FW), .FPOLY(FPOLY)) u_m_tx3 (.a(t), .b(ax), .p(tx3));

    assign ay = tx3 ^ zwv;
endmodule

// File: rtl/bin_jac_dbl_add.sv
// Module: top of the combined doubling/addition unit. Runs both branches
// in parallel, resolves infinity / equal-point cases and registers both
// results with a one-cycle valid.
// Assumes: inputs are points of the configured curve; Z = 0 means infinity.
module bin_jac_dbl_add #(
    parameter int              FW    = 7,
    parameter logic [FW-1:0]   FPOLY = 'h03,
    parameter logic [FW-1:0]   CA    = 'h01,
    parameter logic [FW-1:0]   CB    = 'h01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [FW-1:0] p1_x,
    input  logic [FW-1:0] p1_y,
    input  logic [FW-1:0] p1_z,
    input  logic [FW-1:0] p2_x,
    input  logic [FW-1:0] p2_y,
    input  logic [FW-1:0] p2_z,
    output logic          out_valid,
    output logic [FW-1:0] dbl_x,
    output logic [FW-1:0] dbl_y,
    output logic [FW-1:0] dbl_z,
    output logic [FW-1:0] sum_x,
    output logic [FW-1:0] sum_y,
    output logic [FW-1:0] sum_z
);
    import bjda_pkg::*;

    localparam logic [FW-1:0] FONE = FW'(1);

    logic [FW-1:0] z1_sq, d_x, d_y, d_z, a_x, a_y, a_z;
    logic [FW-1:0] nd_x, nd_y, nd_z, ns_x, ns_y, ns_z;
    logic          w_zero, r_zero, z1_zero, z2_zero;
    sum_src_e      src;

    bjda_dbl_path #(.FW(FW), .FPOLY(FPOLY), .CB(CB)) u_dbl (
        .x1(p1_x), .y1(p1_y), .z1(p1_z), .z1_sq(z1_sq),
        .dx(d_x), .dy(d_y), .dz(d_z)
    );

    bjda_add_path #(.FW(FW), .FPOLY(FPOLY), .CA(CA)) u_add (
        .x1(p1_x), .y1(p1_y), .z1(p1_z), .z1_sq(z1_sq),
        .x2(p2_x), .y2(p2_y), .z2(p2_z),
        .ax(a_x), .ay(a_y), .az(a_z), .w_zero(w_zero), .r_zero(r_zero)
    );

    assign z1_zero = (p1_z == '0);
    assign z2_zero = (p2_z == '0);
    assign src     = pick_sum_src(z1_zero, z2_zero, w_zero, r_zero);

    // Doubled result: canonical infinity when the first input is at infinity.
    always_comb begin
        if (z1_zero) begin
            nd_x = FONE;
            nd_y = FONE;
            nd_z = '0;
        end else begin
            nd_x = d_x;
            nd_y = d_y;
            nd_z = d_z;
        end
    end

    // Sum result: pick formula, passthrough or doubled result.
    always_comb begin
        unique case (src)
            SUM_TAKE_P2:  begin ns_x = p2_x; ns_y = p2_y; ns_z = p2_z; end
            SUM_TAKE_P1:  begin ns_x = p1_x; ns_y = p1_y; ns_z = p1_z; end
            SUM_TAKE_DBL: begin ns_x = d_x;  ns_y = d_y;  ns_z = d_z;  end
            default:      begin ns_x = a_x;  ns_y = a_y;  ns_z = a_z;  end
        endcase
    end

    // Output register: capture on in_valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            dbl_x <= '0; dbl_y <= '0; dbl_z <= '0;
            sum_x <= '0; sum_y <= '0; sum_z <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                dbl_x <= nd_x; dbl_y <= nd_y; dbl_z <= nd_z;
                sum_x <= ns_x; sum_y <= ns_y; sum_z <= ns_z;
            end
        end
    end
endmodule

// File: rtl/bjda_checker.sv
// Module: temporal checks on the ports of bin_jac_dbl_add, bound to it below.
module bjda_checker #(
    parameter int FW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [FW-1:0] p1_x,
    input logic [FW-1:0] p1_y,
    input logic [FW-1:0] p1_z,
    input logic [FW-1:0] p2_x,
    input logic [FW-1:0] p2_y,
    input logic [FW-1:0] p2_z,
    input logic          out_valid,
    input logic [FW-1:0] dbl_x,
    input logic [FW-1:0] dbl_y,
    input logic [FW-1:0] dbl_z,
    input logic [FW-1:0] sum_x,
    input logic [FW-1:0] sum_y,
    input logic [FW-1:0] sum_z
);
    // R10: reset clears valid and results.
    a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && dbl_z == '0 && sum_z == '0));

    // R8: valid follows input valid by one cycle.
    a_r8_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9: no new input means valid low and results held.
    a_r9_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(dbl_x) && $stable(dbl_y) && $stable(dbl_z)
                       && $stable(sum_x) && $stable(sum_y) && $stable(sum_z)));

    // R6: first input at infinity.
    a_r6_p1_infinity: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && p1_z == '0) |=> (dbl_x == FW'(1) && dbl_y == FW'(1) && dbl_z == '0
            && sum_x == $past(p2_x) && sum_y == $past(p2_y) && sum_z == $past(p2_z)));

    // R7: second input at infinity.
    a_r7_p2_infinity: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && p1_z != '0 && p2_z == '0) |=> (sum_x == $past(p1_x)
            && sum_y == $past(p1_y) && sum_z == $past(p1_z)));

    // R5: affine x of zero doubles to infinity.
    a_r5_x_zero_doubles_inf: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && p1_z != '0 && p1_x == '0) |=> (dbl_z == '0));

    // R4: identical inputs give sum equal to the doubled result.
    a_r4_equal_inputs: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && p1_z != '0 && p1_x == p2_x && p1_y == p2_y && p1_z == p2_z)
        |=> (sum_x == dbl_x && sum_y == dbl_y && sum_z == dbl_z));
endmodule

bind bin_jac_dbl_add bjda_checker #(.FW(FW)) u_bjda_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .p1_x(p1_x), .p1_y(p1_y), .p1_z(p1_z),
    .p2_x(p2_x), .p2_y(p2_y), .p2_z(p2_z),
    .out_valid(out_valid),
    .dbl_x(dbl_x), .dbl_y(dbl_y), .dbl_z(dbl_z),
    .sum_x(sum_x), .sum_y(sum_y), .sum_z(sum_z)
);

// File: tb/bin_jac_dbl_add_tb_top.sv
// Bench: enumerates the curve points, then drives directed and random
// point pairs and checks results in affine form against a group-law model.
module bin_jac_dbl_add_tb_top;
    localparam int            M      = 7;
    localparam logic [M-1:0]  PL     = 7'h03;
    localparam logic [M-1:0]  CA     = 7'h01;
    localparam logic [M-1:0]  CB     = 7'h01;
    localparam int            CLK_NS = 10;
    localparam int            NRAND  = 400;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [M-1:0] p1_x = '0, p1_y = '0, p1_z = '0, p2_x = '0, p2_y = '0, p2_z = '0;
    logic         out_valid;
    logic [M-1:0] dbl_x, dbl_y, dbl_z, sum_x, sum_y, sum_z;

    int total = 0;
    int bad = 0;

    logic [M-1:0] px [0:255];
    logic [M-1:0] py [0:255];
    int np = 0;

    always #(CLK_NS/2) clk = ~clk;

    bin_jac_dbl_add #(.FW(M), .FPOLY(PL), .CA(CA), .CB(CB)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .p1_x(p1_x), .p1_y(p1_y), .p1_z(p1_z),
        .p2_x(p2_x), .p2_y(p2_y), .p2_z(p2_z),
        .out_valid(out_valid),
        .dbl_x(dbl_x), .dbl_y(dbl_y), .dbl_z(dbl_z),
        .sum_x(sum_x), .sum_y(sum_y), .sum_z(sum_z)
    );

    // Schoolbook product followed by reduction by x^M + PL.
    function automatic logic [M-1:0] fmul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [2*M-2:0] w;
        w = '0;
        for (int i = 0; i < M; i++)
            if (b[i]) w = w ^ ((2*M-1)'(a) << i);
        for (int j = 2*M-2; j >= M; j--)
            if (w[j]) w = w ^ ((2*M-1)'(1) << j) ^ ((2*M-1)'(PL) << (j - M));
        return w[M-1:0];
    endfunction

    function automatic logic [M-1:0] fsq(input logic [M-1:0] a);
        return fmul(a, a);
    endfunction

    // Inverse as a^(2^M - 2).
    function automatic logic [M-1:0] finv(input logic [M-1:0] a);
        logic [M-1:0] r, t;
        r = M'(1);
        t = a;
        for (int i = 1; i < M; i++) begin
            t = fsq(t);
            r = fmul(r, t);
        end
        return r;
    endfunction

    // Check one projective result against an expected affine point.
    task automatic chk(input string req, input logic [M-1:0] X, input logic [M-1:0] Y,
                       input logic [M-1:0] Z, input bit e_inf,
                       input logic [M-1:0] ex, input logic [M-1:0] ey);
        logic [M-1:0] zi, ax, ay;
        total++;
        if (e_inf) begin
            if (Z != '0) begin
                bad++;
                $display("FAIL %s: Z=%h expected 0 (infinity)", req, Z);
            end
        end else begin
            zi = finv(Z);
            ax = fmul(X, fsq(zi));
            ay = fmul(Y, fmul(fsq(zi), zi));
            if (Z == '0 || ax != ex || ay != ey) begin
                bad++;
                $display("FAIL %s: affine (%h,%h) Z=%h expected (%h,%h)", req, ax, ay, Z, ex, ey);
            end
        end
    endtask

    task automatic chk_eq(input string req, input logic [M-1:0] act, input logic [M-1:0] exp_v);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp_v);
        end
    endtask

    // Affine doubling per the group law.
    task automatic ref_dbl(input logic [M-1:0] x, input logic [M-1:0] y,
                           output bit inf, output logic [M-1:0] rx, output logic [M-1:0] ry);
        logic [M-1:0] l;
        inf = (x == '0);
        rx = '0; ry = '0;
        if (!inf) begin
            l  = x ^ fmul(y, finv(x));
            rx = fsq(l) ^ l ^ CA;
            ry = fsq(x) ^ fmul(l ^ M'(1), rx);
        end
    endtask

    // Affine addition per the group law.
    task automatic ref_add(input logic [M-1:0] x1, input logic [M-1:0] y1,
                           input logic [M-1:0] x2, input logic [M-1:0] y2,
                           output bit inf, output logic [M-1:0] rx, output logic [M-1:0] ry);
        logic [M-1:0] l;
        if (x1 == x2) begin
            if (y1 == y2) ref_dbl(x1, y1, inf, rx, ry);
            else begin inf = 1'b1; rx = '0; ry = '0; end
        end else begin
            inf = 1'b0;
            l  = fmul(y1 ^ y2, finv(x1 ^ x2));
            rx = fsq(l) ^ l ^ x1 ^ x2 ^ CA;
            ry = fmul(l, x1 ^ rx) ^ rx ^ y1;
        end
    endtask

    // Apply one pair for a single cycle and return the sampled outputs.
    task automatic apply(input logic [M-1:0] ax1, input logic [M-1:0] ay1, input logic [M-1:0] az1,
                         input logic [M-1:0] ax2, input logic [M-1:0] ay2, input logic [M-1:0] az2);
        @(negedge clk);
        p1_x = ax1; p1_y = ay1; p1_z = az1;
        p2_x = ax2; p2_y = ay2; p2_z = az2;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        total++;
        if (out_valid !== 1'b1) begin
            bad++;
            $display("FAIL R8: out_valid=%b expected 1", out_valid);
        end
    endtask

    // Affine pair with scaling factors, checked for both results.
    task automatic run_pair(input string tag, input int i, input int j,
                            input logic [M-1:0] za, input logic [M-1:0] zb,
                            input logic [M-1:0] yb_override, input bit use_override);
        logic [M-1:0] x1, y1, x2, y2, ex, ey;
        bit einf;
        x1 = px[i]; y1 = py[i];
        x2 = px[j]; y2 = use_override ? yb_override : py[j];
        apply(fmul(x1, fsq(za)), fmul(y1, fmul(fsq(za), za)), za,
              fmul(x2, fsq(zb)), fmul(y2, fmul(fsq(zb), zb)), zb);
        ref_dbl(x1, y1, einf, ex, ey);
        chk(x1 == '0 ? "R5 doubled x=0" : "R1 doubled", dbl_x, dbl_y, dbl_z, einf, ex, ey);
        ref_add(x1, y1, x2, y2, einf, ex, ey);
        chk(tag, sum_x, sum_y, sum_z, einf, ex, ey);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        #(CLK_NS * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        int i0, j0, zero_idx;
        logic [M-1:0] za, zb, hx, hy, hz, sx, sy, sz;
        seed_dummy = $urandom(32'd20240611);

        // Enumerate affine curve points.
        zero_idx = -1;
        for (int x = 0; x < (1 << M); x++)
            for (int y = 0; y < (1 << M); y++)
                if ((fsq(M'(y)) ^ fmul(M'(x), M'(y))) ==
                    (fmul(fsq(M'(x)), M'(x)) ^ fmul(CA, fsq(M'(x))) ^ CB)) begin
                    px[np] = M'(x);
                    py[np] = M'(y);
                    if (x == 0) zero_idx = np;
                    np++;
                end

        // R10: reset state.
        repeat (3) @(negedge clk);
        chk_eq("R10 out_valid in reset", {{(M-1){1'b0}}, out_valid}, '0);
        chk_eq("R10 dbl_x in reset", dbl_x, '0);
        chk_eq("R10 sum_y in reset", sum_y, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: first point at infinity.
        i0 = 3 % np;
        apply(M'(5), M'(9), '0, px[i0], py[i0], M'(1));
        chk_eq("R6 dbl_x", dbl_x, M'(1));
        chk_eq("R6 dbl_y", dbl_y, M'(1));
        chk_eq("R6 dbl_z", dbl_z, '0);
        chk_eq("R6 sum_x", sum_x, px[i0]);
        chk_eq("R6 sum_y", sum_y, py[i0]);
        chk_eq("R6 sum_z", sum_z, M'(1));

        // R7: second point at infinity.
        apply(px[i0], py[i0], M'(1), M'(7), M'(2), '0);
        chk_eq("R7 sum_x", sum_x, px[i0]);
        chk_eq("R7 sum_y", sum_y, py[i0]);
        chk_eq("R7 sum_z", sum_z, M'(1));

        // R5: point with x = 0.
        if (zero_idx >= 0)
            run_pair("R2 sum with x=0 point", zero_idx, (zero_idx + 1) % np, M'(3), M'(1), '0, 1'b0);

        // R4: same affine point with different Z.
        run_pair("R4 equal points", 1 % np, 1 % np, M'(6), M'(11), '0, 1'b0);
        // R3: point plus its negation.
        run_pair("R3 negated point", 2 % np, 2 % np, M'(1), M'(9), px[2 % np] ^ py[2 % np], 1'b1);

        // R9: hold while in_valid is low even as inputs move.
        hx = dbl_x; hy = dbl_y; hz = dbl_z; sx = sum_x; sy = sum_y; sz = sum_z;
        p1_x = ~p1_x; p2_y = ~p2_y; p1_z = p1_z ^ M'(1);
        repeat (2) @(negedge clk);
        chk_eq("R9 out_valid low", {{(M-1){1'b0}}, out_valid}, '0);
        chk_eq("R9 dbl_x held", dbl_x, hx);
        chk_eq("R9 dbl_y held", dbl_y, hy);
        chk_eq("R9 dbl_z held", dbl_z, hz);
        chk_eq("R9 sum_x held", sum_x, sx);
        chk_eq("R9 sum_y held", sum_y, sy);
        chk_eq("R9 sum_z held", sum_z, sz);

        // Random pairs, mixed with forced equal and negated pairs.
        for (int k = 0; k < NRAND; k++) begin
            int mode;
            i0 = int'($urandom % np);
            j0 = int'($urandom % np);
            za = M'($urandom % ((1 << M) - 1) + 1);
            zb = M'($urandom % ((1 << M) - 1) + 1);
            mode = int'($urandom % 8);
            if (mode == 0)
                run_pair("R4 equal points (random)", i0, i0, za, zb, '0, 1'b0);
            else if (mode == 1)
                run_pair("R3 negated point (random)", i0, i0, za, zb, px[i0] ^ py[i0], 1'b1);
            else
                run_pair(px[i0] == px[j0] ? "R4/R3 same x (random)" : "R2 sum (random)",
                         i0, j0, za, zb, '0, 1'b0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule